// File: doc/BRIEF.md
# Channel-Addressed Peripheral Bus Interface

This block is the bus-facing front end of a single peripheral on a programmed-I/O bus. Every bus cycle carries a 6-bit channel number, an operation code, a 2-bit control field and 16 bits of write data. The block acts only when the channel on the bus equals its strapped channel input. It holds three 16-bit data registers, called A, B and C. The bus can load each one (output transfers) or read each one back (input transfers). The registers are also presented to the device-side logic.

The block also keeps a Busy flag and a Done flag. A control field can accompany any transfer except a flag test, and it can start the device, clear it, or request a device-specific action. Each of these produces a one-cycle pulse to the device logic. The device logic reports the end of an operation with a completion strobe. The block answers flag-test queries on a skip output. It raises an interrupt request from Done, gated by a per-device mask bit and a global enable. A global I/O reset returns everything to its power-on state.

Top module: `chio_dev_if`

## Requirements
- R1: A bus cycle is accepted only when `bus_valid` is high and `bus_chan` equals `cfg_chan`. Any other cycle leaves A, B, C, Busy and Done unchanged, produces no pulse, and gives `bus_rdata` = 0 and `bus_skip` = 0.
- R2: Operation codes 1, 3 and 5 load A, B and C respectively with `bus_wdata`. The new value appears on `reg_a`/`reg_b`/`reg_c` one clock after the accepted cycle.
- R3: Operation codes 2, 4 and 6 return A, B and C respectively on `bus_rdata` in the same cycle. `bus_rdata` is 0 for every other operation.
- R4: Control code 1 (start) sets Busy and clears Done on the next clock, and asserts `start_pulse` for exactly that one cycle.
- R5: Control code 2 (clear) clears both Busy and Done on the next clock, and asserts `clear_pulse` for one cycle.
- R6: Control code 3 (special) asserts `special_pulse` for one cycle and does not change Busy or Done. Control code 0 produces no pulse. At most one pulse is high in any cycle.
- R7: The control field acts on operation codes 0 to 6. Its effect follows the data transfer of the same cycle: a read returns the register value from before the edge, and a write and a control both take effect at the same edge.
- R8: Operation code 7 is a flag test that drives no control. Its 2-bit field selects the test: 0 gives Busy set, 1 gives Busy clear, 2 gives Done set, 3 gives Done clear. The result appears on `bus_skip` in the same cycle.
- R9: A `dev_done` strobe while Busy is set clears Busy and sets Done on the next clock. The strobe is ignored while Busy is clear. An accepted start or clear in the same cycle takes precedence over the strobe.
- R10: `io_reset` clears A, B, C, Busy and Done on the next clock, suppresses all pulses, and overrides any bus transfer in the same cycle.
- R11: `irq_req` is high exactly when Done is set, `int_mask` is low and `int_enable` is high.
- R12: After the asynchronous reset `rst_n`, all registers, flags and pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_chan | input | 6 | Strapped channel number of this device |
| bus_valid | input | 1 | A bus cycle is present |
| bus_chan | input | 6 | Channel addressed by the bus cycle |
| bus_op | input | 3 | Operation: 0 control only, 1/3/5 write A/B/C, 2/4/6 read A/B/C, 7 flag test |
| bus_ctl | input | 2 | Control option (0 none, 1 start, 2 clear, 3 special) or test selector for operation 7 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when not reading |
| bus_skip | output | 1 | Result of a flag test |
| io_reset | input | 1 | Global synchronous I/O reset |
| int_mask | input | 1 | Interrupt mask bit for this device |
| int_enable | input | 1 | Global interrupt enable |
| dev_done | input | 1 | Completion strobe from device logic |
| reg_a | output | 16 | Register A contents |
| reg_b | output | 16 | Register B contents |
| reg_c | output | 16 | Register C contents |
| busy | output | 1 | Busy flag |
| done | output | 1 | Done flag |
| start_pulse | output | 1 | One-cycle start command to device logic |
| clear_pulse | output | 1 | One-cycle clear command to device logic |
| special_pulse | output | 1 | One-cycle device-specific command |
| irq_req | output | 1 | Masked interrupt request |

## Verification
Several rules are checked on every cycle by the assertions: the flag and pulse results of start, clear and special commands, the takeover of Busy by Done on completion, the clearing done by the I/O reset, that foreign-channel cycles leave the registers alone, and the gating of the interrupt request. The bench scenarios are needed for the rest. They show that each read returns the right register with its value from before the edge, that each test selector gives the right skip answer, and that a write and a control in one cycle both take effect. They also show that the start-or-clear versus completion precedence and the I/O-reset override hold when random traffic mixes them.

// File: rtl/chio_pkg.sv
`timescale 1ns/1ps
package chio_pkg;

  typedef enum logic [2:0] {
    OP_CTRL  = 3'd0,
    OP_OUT_A = 3'd1,
    OP_IN_A  = 3'd2,
    OP_OUT_B = 3'd3,
    OP_IN_B  = 3'd4,
    OP_OUT_C = 3'd5,
    OP_IN_C  = 3'd6,
    OP_TEST  = 3'd7
  } chio_op_e;

  typedef enum logic [1:0] {
    CTL_NONE    = 2'd0,
    CTL_START   = 2'd1,
    CTL_CLEAR   = 2'd2,
    CTL_SPECIAL = 2'd3
  } chio_ctl_e;

  typedef enum logic [1:0] {
    TST_BUSY_SET = 2'd0,
    TST_BUSY_CLR = 2'd1,
    TST_DONE_SET = 2'd2,
    TST_DONE_CLR = 2'd3
  } chio_test_e;

  typedef struct packed {
    logic start;
    logic clear;
    logic special;
  } chio_cmd_s;

  localparam int unsigned CHIO_NUM_REGS = 3;

endpackage

// File: rtl/chio_rst_sync.sv
`timescale 1ns/1ps
module chio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/chio_decode.sv
`timescale 1ns/1ps
module chio_decode
  import chio_pkg::*;
#(
  parameter int unsigned CHAN_W = 6,
  parameter int unsigned NREGS  = CHIO_NUM_REGS
) (
  input  logic              bus_valid,
  input  logic [CHAN_W-1:0] bus_chan,
  input  logic [CHAN_W-1:0] cfg_chan,
  input  logic [2:0]        bus_op,
  input  logic [1:0]        bus_ctl,
  output logic              hit,
  output logic [NREGS-1:0]  wr_en,
  output logic [NREGS-1:0]  rd_sel,
  output logic              test_en,
  output chio_test_e        test_sel,
  output chio_cmd_s         cmd
);
  logic ctl_allowed;

  always_comb begin
    hit         = bus_valid && (bus_chan == cfg_chan);
    test_en     = hit && (chio_op_e'(bus_op) == OP_TEST);
    ctl_allowed = hit && !test_en;
    test_sel    = chio_test_e'(bus_ctl);
    cmd.start   = ctl_allowed && (chio_ctl_e'(bus_ctl) == CTL_START);
    cmd.clear   = ctl_allowed && (chio_ctl_e'(bus_ctl) == CTL_CLEAR);
    cmd.special = ctl_allowed && (chio_ctl_e'(bus_ctl) == CTL_SPECIAL);
  end

  // Register k: write opcode 2k+1, read opcode 2k+2.
  for (genvar k = 0; k < NREGS; k++) begin : g_sel
    localparam logic [2:0] WR_CODE = 3'(2 * k + 1);
    localparam logic [2:0] RD_CODE = 3'(2 * k + 2);
    always_comb begin
      wr_en[k]  = hit && (bus_op == WR_CODE);
      rd_sel[k] = hit && (bus_op == RD_CODE);
    end
  end
endmodule

// File: rtl/chio_regfile.sv
`timescale 1ns/1ps
module chio_regfile #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NREGS  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    io_reset,
  input  logic [NREGS-1:0]        wr_en,
  input  logic [NREGS-1:0]        rd_sel,
  input  logic [DATA_W-1:0]       wdata,
  output logic [NREGS*DATA_W-1:0] regs_flat,
  output logic [DATA_W-1:0]       rdata
);
  logic [DATA_W-1:0] reg_q [NREGS];

  for (genvar k = 0; k < NREGS; k++) begin : g_reg
    logic              reg_en;
    logic [DATA_W-1:0] reg_d;

    always_comb begin
      reg_en = io_reset || wr_en[k];
      reg_d  = io_reset ? '0 : wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[k] <= '0;
      end else if (reg_en) begin
        reg_q[k] <= reg_d;
      end
    end

    assign regs_flat[k*DATA_W +: DATA_W] = reg_q[k];
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NREGS; k++) begin
      rdata = rdata | (reg_q[k] & {DATA_W{rd_sel[k]}});
    end
  end
endmodule

// File: rtl/chio_flags.sv
`timescale 1ns/1ps
module chio_flags
  import chio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_reset,
  input  chio_cmd_s  cmd,
  input  logic       dev_done,
  input  logic       test_en,
  input  chio_test_e test_sel,
  input  logic       int_mask,
  input  logic       int_enable,
  output logic       busy,
  output logic       done,
  output logic       start_pulse,
  output logic       clear_pulse,
  output logic       special_pulse,
  output logic       skip,
  output logic       irq_req
);
  logic      busy_q, busy_d;
  logic      done_q, done_d;
  chio_cmd_s pulse_q, pulse_d;

  always_comb begin
    busy_d  = busy_q;
    done_d  = done_q;
    pulse_d = cmd;
    if (io_reset) begin
      busy_d  = 1'b0;
      done_d  = 1'b0;
      pulse_d = '0;
    end else if (cmd.clear) begin
      busy_d = 1'b0;
      done_d = 1'b0;
    end else if (cmd.start) begin
      busy_d = 1'b1;
      done_d = 1'b0;
    end else if (dev_done && busy_q) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      pulse_q <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      pulse_q <= pulse_d;
    end
  end

  always_comb begin
    skip = 1'b0;
    if (test_en) begin
      unique case (test_sel)
        TST_BUSY_SET: skip = busy_q;
        TST_BUSY_CLR: skip = !busy_q;
        TST_DONE_SET: skip = done_q;
        TST_DONE_CLR: skip = !done_q;
        default:      skip = 1'b0;
      endcase
    end
  end

  assign busy          = busy_q;
  assign done          = done_q;
  assign start_pulse   = pulse_q.start;
  assign clear_pulse   = pulse_q.clear;
  assign special_pulse = pulse_q.special;
  assign irq_req       = done_q && !int_mask && int_enable;
endmodule

// File: rtl/chio_dev_if.sv
`timescale 1ns/1ps
module chio_dev_if
  import chio_pkg::*;
#(
  parameter int unsigned CHAN_W    = 6,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAN_W-1:0] cfg_chan,
  input  logic              bus_valid,
  input  logic [CHAN_W-1:0] bus_chan,
  input  logic [2:0]        bus_op,
  input  logic [1:0]        bus_ctl,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_skip,
  input  logic              io_reset,
  input  logic              int_mask,
  input  logic              int_enable,
  input  logic              dev_done,
  output logic [DATA_W-1:0] reg_a,
  output logic [DATA_W-1:0] reg_b,
  output logic [DATA_W-1:0] reg_c,
  output logic              busy,
  output logic              done,
  output logic              start_pulse,
  output logic              clear_pulse,
  output logic              special_pulse,
  output logic              irq_req
);
  localparam int unsigned NREGS = CHIO_NUM_REGS;

  logic                    rst_sync_n;
  logic                    hit;
  logic [NREGS-1:0]        wr_en;
  logic [NREGS-1:0]        rd_sel;
  logic                    test_en;
  chio_test_e              test_sel;
  chio_cmd_s               cmd;
  logic [NREGS*DATA_W-1:0] regs_flat;

  chio_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  chio_decode #(.CHAN_W(CHAN_W), .NREGS(NREGS)) u_dec (
    .bus_valid (bus_valid),
    .bus_chan  (bus_chan),
    .cfg_chan  (cfg_chan),
    .bus_op    (bus_op),
    .bus_ctl   (bus_ctl),
    .hit       (hit),
    .wr_en     (wr_en),
    .rd_sel    (rd_sel),
    .test_en   (test_en),
    .test_sel  (test_sel),
    .cmd       (cmd)
  );

  chio_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .io_reset  (io_reset),
    .wr_en     (wr_en),
    .rd_sel    (rd_sel),
    .wdata     (bus_wdata),
    .regs_flat (regs_flat),
    .rdata     (bus_rdata)
  );

  chio_flags u_flags (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .io_reset      (io_reset),
    .cmd           (cmd),
    .dev_done      (dev_done),
    .test_en       (test_en),
    .test_sel      (test_sel),
    .int_mask      (int_mask),
    .int_enable    (int_enable),
    .busy          (busy),
    .done          (done),
    .start_pulse   (start_pulse),
    .clear_pulse   (clear_pulse),
    .special_pulse (special_pulse),
    .skip          (bus_skip),
    .irq_req       (irq_req)
  );

  assign reg_a = regs_flat[0*DATA_W +: DATA_W];
  assign reg_b = regs_flat[1*DATA_W +: DATA_W];
  assign reg_c = regs_flat[2*DATA_W +: DATA_W];

  logic unused_hit;
  assign unused_hit = hit;
endmodule

// File: rtl/chio_dev_if_chk.sv
`timescale 1ns/1ps
module chio_dev_if_chk #(
  parameter int unsigned CHAN_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_ok,
  input logic [CHAN_W-1:0] cfg_chan,
  input logic              bus_valid,
  input logic [CHAN_W-1:0] bus_chan,
  input logic [2:0]        bus_op,
  input logic [1:0]        bus_ctl,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_skip,
  input logic              io_reset,
  input logic              int_mask,
  input logic              int_enable,
  input logic              dev_done,
  input logic [DATA_W-1:0] reg_a,
  input logic [DATA_W-1:0] reg_b,
  input logic [DATA_W-1:0] reg_c,
  input logic              busy,
  input logic              done,
  input logic              start_pulse,
  input logic              clear_pulse,
  input logic              special_pulse,
  input logic              irq_req
);
  logic acc, ctl_ok;
  assign acc    = bus_valid && (bus_chan == cfg_chan);
  assign ctl_ok = acc && (bus_op != 3'd7) && !io_reset;

  // R1
  foreign_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!acc && !io_reset) |=> ($stable(reg_a) && $stable(reg_b) && $stable(reg_c)));

  // R1
  foreign_silent_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !acc |-> (bus_rdata == '0 && !bus_skip));

  // R4
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (ctl_ok && bus_ctl == 2'd1) |=> (busy && !done && start_pulse));

  // R5
  clear_drops_flags_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (ctl_ok && bus_ctl == 2'd2) |=> (!busy && !done && clear_pulse));

  // R6
  special_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (ctl_ok && bus_ctl == 2'd3 && !dev_done) |=>
      (special_pulse && $stable(busy) && $stable(done)));

  // R6
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0({start_pulse, clear_pulse, special_pulse}));

  // R9
  completion_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (dev_done && busy && !io_reset && !(ctl_ok && (bus_ctl == 2'd1 || bus_ctl == 2'd2)))
      |=> (done && !busy));

  // R10
  io_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    io_reset |=> (reg_a == '0 && reg_b == '0 && reg_c == '0 && !busy && !done &&
                  !start_pulse && !clear_pulse && !special_pulse));

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    irq_req |-> (done && !int_mask && int_enable));
endmodule

bind chio_dev_if chio_dev_if_chk #(.CHAN_W(CHAN_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_ok        (rst_sync_n),
  .cfg_chan      (cfg_chan),
  .bus_valid     (bus_valid),
  .bus_chan      (bus_chan),
  .bus_op        (bus_op),
  .bus_ctl       (bus_ctl),
  .bus_rdata     (bus_rdata),
  .bus_skip      (bus_skip),
  .io_reset      (io_reset),
  .int_mask      (int_mask),
  .int_enable    (int_enable),
  .dev_done      (dev_done),
  .reg_a         (reg_a),
  .reg_b         (reg_b),
  .reg_c         (reg_c),
  .busy          (busy),
  .done          (done),
  .start_pulse   (start_pulse),
  .clear_pulse   (clear_pulse),
  .special_pulse (special_pulse),
  .irq_req       (irq_req)
);

// File: tb/chio_dev_if_tb_top.sv
`timescale 1ns/1ps
module chio_dev_if_tb_top;
  localparam logic [5:0] MY_CHAN = 6'd37;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  cfg_chan;
  logic        bus_valid;
  logic [5:0]  bus_chan;
  logic [2:0]  bus_op;
  logic [1:0]  bus_ctl;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        bus_skip;
  logic        io_reset, int_mask, int_enable, dev_done;
  logic [15:0] reg_a, reg_b, reg_c;
  logic        busy, done, start_pulse, clear_pulse, special_pulse, irq_req;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // model state
  logic [15:0] m_reg [3];
  logic        m_busy, m_done;
  logic [2:0]  m_pulse; // {start, clear, special}

  always #2 clk = ~clk;

  chio_dev_if dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_chan(cfg_chan),
    .bus_valid(bus_valid), .bus_chan(bus_chan), .bus_op(bus_op),
    .bus_ctl(bus_ctl), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_skip(bus_skip), .io_reset(io_reset), .int_mask(int_mask),
    .int_enable(int_enable), .dev_done(dev_done),
    .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c),
    .busy(busy), .done(done), .start_pulse(start_pulse),
    .clear_pulse(clear_pulse), .special_pulse(special_pulse),
    .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rdata(input logic acc, input logic [2:0] op);
    if (!acc) return 16'h0;
    case (op)
      3'd2: return m_reg[0];
      3'd4: return m_reg[1];
      3'd6: return m_reg[2];
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic exp_skip(input logic acc, input logic [2:0] op, input logic [1:0] sel);
    if (!acc || op != 3'd7) return 1'b0;
    case (sel)
      2'd0: return m_busy;
      2'd1: return !m_busy;
      2'd2: return m_done;
      default: return !m_done;
    endcase
  endfunction

  task automatic cycle(input logic v, input logic [5:0] ch, input logic [2:0] op,
                       input logic [1:0] ctl, input logic [15:0] wd, input logic dd,
                       input logic ior, input logic msk, input logic en);
    logic acc;
    logic [1:0] c;
    bus_valid = v; bus_chan = ch; bus_op = op; bus_ctl = ctl; bus_wdata = wd;
    dev_done = dd; io_reset = ior; int_mask = msk; int_enable = en;
    #1;
    acc = v && (ch == MY_CHAN);
    check("R3 read data", bus_rdata, exp_rdata(acc, op));
    check("R8 skip answer", bus_skip, exp_skip(acc, op, ctl));
    check("R11 irq", irq_req, m_done && !msk && en);
    // model next state
    c = (acc && op != 3'd7) ? ctl : 2'd0;
    if (ior) begin
      for (int k = 0; k < 3; k++) m_reg[k] = 16'h0;
      m_busy = 0; m_done = 0; m_pulse = 3'b000;
    end else begin
      if (acc && (op == 3'd1 || op == 3'd3 || op == 3'd5)) m_reg[op >> 1] = wd;
      m_pulse = {c == 2'd1, c == 2'd2, c == 2'd3};
      if (c == 2'd2) begin m_busy = 0; m_done = 0; end
      else if (c == 2'd1) begin m_busy = 1; m_done = 0; end
      else if (dd && m_busy) begin m_busy = 0; m_done = 1; end
    end
    @(negedge clk);
    check("R2/R10 reg A", reg_a, m_reg[0]);
    check("R2/R10 reg B", reg_b, m_reg[1]);
    check("R2/R10 reg C", reg_c, m_reg[2]);
    check("R4/R5/R9 busy", busy, m_busy);
    check("R4/R5/R9 done", done, m_done);
    check("R6 pulses", {start_pulse, clear_pulse, special_pulse}, m_pulse);
  endtask

  initial begin
    void'($urandom(32'd4242));
    cfg_chan = MY_CHAN; rst_n = 1'b0;
    bus_valid = 0; bus_chan = 0; bus_op = 0; bus_ctl = 0; bus_wdata = 0;
    dev_done = 0; io_reset = 0; int_mask = 0; int_enable = 1;
    for (int k = 0; k < 3; k++) m_reg[k] = 16'h0;
    m_busy = 0; m_done = 0; m_pulse = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 reset regs", {reg_a, reg_b, reg_c} == 48'h0, 1);
    check("R12 reset flags", {busy, done, start_pulse, clear_pulse, special_pulse, irq_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: foreign channel write and start ignored
    cycle(1, 6'd36, 3'd1, 2'd1, 16'hBEEF, 0, 0, 0, 1);
    // R2/R7: write A together with start
    cycle(1, MY_CHAN, 3'd1, 2'd1, 16'h1234, 0, 0, 0, 1);
    // R7: read A with clear returns old value, then clear applies
    cycle(1, MY_CHAN, 3'd2, 2'd2, 16'h0, 0, 0, 0, 1);
    // R9: completion ignored while idle
    cycle(0, 6'd0, 3'd0, 2'd0, 16'h0, 1, 0, 0, 1);
    // R9: start, then completion, then R11 irq with mask
    cycle(1, MY_CHAN, 3'd0, 2'd1, 16'h0, 0, 0, 0, 1);
    cycle(0, 6'd0, 3'd0, 2'd0, 16'h0, 1, 0, 0, 1);
    cycle(0, 6'd0, 3'd0, 2'd0, 16'h0, 0, 0, 1, 1);
    // R8: all four tests in Done state
    for (int s = 0; s < 4; s++) cycle(1, MY_CHAN, 3'd7, 2'(s), 16'h0, 0, 0, 0, 1);
    // R6: special keeps flags
    cycle(1, MY_CHAN, 3'd5, 2'd3, 16'h55AA, 0, 0, 0, 0);
    // R10: io_reset overrides write and start
    cycle(1, MY_CHAN, 3'd3, 2'd1, 16'hFFFF, 0, 1, 0, 1);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] ch;
      ch = ($urandom % 4 == 0) ? 6'($urandom) : MY_CHAN;
      cycle(($urandom % 8) != 0, ch, 3'($urandom), 2'($urandom), 16'($urandom),
            ($urandom % 3) == 0, ($urandom % 97) == 0, ($urandom % 4) == 0,
            ($urandom % 5) != 0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule